// File: doc/BRIEF.md
# Indexed Debug-Memory Read Port

This block gives a simple register bus read access to three internal 64-bit memories. Each memory appears at only one CSR address. A shared cursor register selects the entry that the next memory read returns. The cursor register holds two fields: a 16-bit read index and a 16-bit stride. Each read of a memory-backed address adds the stride to the index. Software loads the cursor once and can then read a whole memory with back-to-back reads at that one address.

The memories hold 32, 256 and 256 entries. Their contents come from an internal debug-write port that sits beside the bus. The bus uses a single-beat request. A read response arrives one cycle after the request, marked by a valid strobe.

CSR map, where the address bits set the behaviour: address 0 is the cursor register, addresses 1, 2 and 3 are memories 0, 1 and 2, and every other address is unmapped.

Top module: `dbg_mem_rd_port`

## Requirements
- R1: After synchronous reset the cursor index and stride are both zero and `rsp_valid` is low.
- R2: A write to address 0 loads the index from `req_wdata[15:0]` and the stride from `req_wdata[31:16]`. A read of address 0 returns the index in bits [15:0] and the stride in bits [31:16], with bits [63:32] zero.
- R3: Each read request gives exactly one `rsp_valid` pulse in the following cycle. A write request gives no response.
- R4: A read of address 1, 2 or 3 returns the entry of memory 0, 1 or 2 selected by the index value in effect when the request is made.
- R5: After each read of a memory address, the index becomes index plus stride, modulo 2^16. The stride is unchanged.
- R6: A read of address 0 or of an unmapped address (4 to 15) leaves the index unchanged. An unmapped read returns zero.
- R7: Each memory uses only the low log2(depth) bits of the index. For example, index 33 on the 32-entry memory reads entry 1.
- R8: With stride 0, repeated reads return the same entry.
- R9: A bus write to a memory address changes neither that memory's contents nor the cursor.
- R10: The debug-write port stores `dbg_wr_data` at entry `dbg_wr_addr` of the memory chosen by `dbg_wr_sel` (0, 1 or 2).
- R11: With index 0 and stride 1, consecutive reads return a memory's entries in ascending order. The order wraps back to entry 0 after the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | CSR address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 64 | Read data |
| dbg_wr_en | input | 1 | Debug-write strobe |
| dbg_wr_sel | input | 2 | Target memory of the debug write |
| dbg_wr_addr | input | 8 | Entry written by the debug write |
| dbg_wr_data | input | 64 | Debug-write data |

## Verification
The bench fills every entry of all three memories with an address-derived pattern. It then reads each memory back with stride 1 and a final wrapping read, so a design that skipped an increment, or read the updated index rather than the old one, would return shifted data. It also checks these cases:
- Stride 3 past the end of a 256-entry memory, and stride 0xFFFF (a step of -1).
- A 16-bit index overflow.
- An index above the depth of the 32-entry memory, which would fetch the wrong entry if the design failed to truncate the index.
- Reads of the cursor register and of unmapped addresses, which a faulty design would let advance the index.
- A bus write to a memory address, which a faulty design would let corrupt an entry.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  localparam int CSR_AW   = 4;
  localparam int CSR_DW   = 64;
  localparam int IDX_W    = 16;
  localparam int NUM_MEM  = 3;
  localparam int SEL_W    = 2;

  localparam logic [CSR_AW-1:0] CSR_CURSOR   = 4'd0;
  localparam logic [CSR_AW-1:0] CSR_MEM_BASE = 4'd1;

  function automatic logic is_mem_csr(input logic [CSR_AW-1:0] a);
    return (a >= CSR_MEM_BASE) && (a < CSR_MEM_BASE + NUM_MEM);
  endfunction
endpackage

// File: rtl/dmr_mem.sv
module dmr_mem #(
  parameter int DEPTH = 32,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) q <= store[raddr];
  end
endmodule

// File: rtl/dmr_cursor.sv
module dmr_cursor #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [IW-1:0] load_idx,
  input  logic [IW-1:0] load_step,
  input  logic          advance,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] step
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      step <= '0;
    end else if (load) begin
      idx  <= load_idx;
      step <= load_step;
    end else if (advance) begin
      idx  <= idx + step;
    end
  end
endmodule

// File: rtl/dbg_mem_rd_port.sv
module dbg_mem_rd_port #(
  parameter int DEPTH0 = 32,
  parameter int DEPTH1 = 256,
  parameter int DEPTH2 = 256,
  parameter int DBG_AW = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [dmr_pkg::CSR_AW-1:0] req_addr,
  input  logic [dmr_pkg::CSR_DW-1:0] req_wdata,
  output logic                       rsp_valid,
  output logic [dmr_pkg::CSR_DW-1:0] rsp_rdata,
  input  logic                       dbg_wr_en,
  input  logic [dmr_pkg::SEL_W-1:0]  dbg_wr_sel,
  input  logic [DBG_AW-1:0]          dbg_wr_addr,
  input  logic [dmr_pkg::CSR_DW-1:0] dbg_wr_data
);
  import dmr_pkg::*;

  localparam int CW = 2 * IDX_W;

  logic             rd_req, wr_req, cursor_load, cursor_adv;
  logic [IDX_W-1:0] idx_q, step_q;
  logic             rsp_valid_q;
  logic [CSR_AW-1:0] sel_q;
  logic [CW-1:0]    snap_q;
  logic [CSR_DW-1:0] mem_q [NUM_MEM];
  logic             unused_wdata_hi;

  assign rd_req      = req_valid && !req_write;
  assign wr_req      = req_valid &&  req_write;
  assign cursor_load = wr_req && (req_addr == CSR_CURSOR);
  assign cursor_adv  = rd_req && is_mem_csr(req_addr);
  assign unused_wdata_hi = ^req_wdata[CSR_DW-1:CW];

  dmr_cursor #(.IW(IDX_W)) i_cursor (
    .clk       (clk),
    .rst       (rst),
    .load      (cursor_load),
    .load_idx  (req_wdata[IDX_W-1:0]),
    .load_step (req_wdata[CW-1:IDX_W]),
    .advance   (cursor_adv),
    .idx       (idx_q),
    .step      (step_q)
  );

  for (genvar g = 0; g < NUM_MEM; g++) begin : g_mem
    localparam int D  = (g == 0) ? DEPTH0 : ((g == 1) ? DEPTH1 : DEPTH2);
    localparam int LA = $clog2(D);
    logic hit_rd, hit_wr;
    assign hit_rd = rd_req && (req_addr == CSR_MEM_BASE + CSR_AW'(g));
    assign hit_wr = dbg_wr_en && (dbg_wr_sel == SEL_W'(g));

    dmr_mem #(.DEPTH(D), .DW(CSR_DW)) i_mem (
      .clk   (clk),
      .we    (hit_wr),
      .waddr (dbg_wr_addr[LA-1:0]),
      .wdata (dbg_wr_data),
      .re    (hit_rd),
      .raddr (idx_q[LA-1:0]),
      .q     (mem_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      sel_q       <= '0;
      snap_q      <= '0;
    end else begin
      rsp_valid_q <= rd_req;
      if (rd_req) begin
        sel_q  <= req_addr;
        snap_q <= {step_q, idx_q};
      end
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (sel_q == CSR_CURSOR) begin
      rsp_rdata = {{(CSR_DW-CW){1'b0}}, snap_q};
    end else begin
      for (int m = 0; m < NUM_MEM; m++) begin
        if (sel_q == CSR_MEM_BASE + CSR_AW'(m)) rsp_rdata = mem_q[m];
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
endmodule

// File: rtl/dmr_chk.sv
module dmr_chk (
  input logic                       clk,
  input logic                       rst,
  input logic                       req_valid,
  input logic                       req_write,
  input logic [dmr_pkg::CSR_AW-1:0] req_addr,
  input logic [dmr_pkg::CSR_DW-1:0] req_wdata,
  input logic                       rsp_valid,
  input logic [dmr_pkg::CSR_DW-1:0] rsp_rdata,
  input logic [dmr_pkg::IDX_W-1:0]  idx,
  input logic [dmr_pkg::IDX_W-1:0]  step
);
  import dmr_pkg::*;

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid); // R3
  AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid); // R3
  AST_CURSOR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == CSR_CURSOR) |=>
      (idx == $past(req_wdata[IDX_W-1:0]) && step == $past(req_wdata[2*IDX_W-1:IDX_W]))); // R2
  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && is_mem_csr(req_addr)) |=>
      (idx == IDX_W'($past(idx) + $past(step)) && $stable(step))); // R5
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !is_mem_csr(req_addr)) |=> ($stable(idx) && $stable(step))); // R6
  AST_MEM_WRITE_NO_CURSOR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && is_mem_csr(req_addr)) |=> ($stable(idx) && $stable(step))); // R9
  AST_CURSOR_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_addr) == CSR_CURSOR) |-> (rsp_rdata[CSR_DW-1:2*IDX_W] == '0)); // R2
endmodule

bind dbg_mem_rd_port dmr_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .idx       (idx_q),
  .step      (step_q)
);

// File: tb/test_dbg_mem_rd_port.sv
`timescale 1ns/1ps
module test_dbg_mem_rd_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        dbg_wr_en = 1'b0;
  logic [1:0]  dbg_wr_sel = '0;
  logic [7:0]  dbg_wr_addr = '0;
  logic [63:0] dbg_wr_data = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_mem_rd_port i_dbg_mem_rd_port (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .dbg_wr_en(dbg_wr_en), .dbg_wr_sel(dbg_wr_sel),
    .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
  );

  function automatic logic [63:0] pat(input int m, input int a);
    logic [47:0] lo = 48'(a * 32'h9E37 + m * 32'h1234 + 1);
    return {8'(m + 16), 8'(a), lo};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 rsp_valid after read", 64'(rsp_valid), 64'd1);
    d = rsp_rdata;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R3 no rsp on write", 64'(rsp_valid), 64'd0);
  endtask

  task automatic set_cursor(input int ix, input int st);
    bus_wr(4'd0, {32'h0, 16'(st), 16'(ix)});
  endtask

  task automatic dbg_wr(input int m, input int a, input logic [63:0] d);
    @(negedge clk);
    dbg_wr_en = 1'b1; dbg_wr_sel = 2'(m); dbg_wr_addr = 8'(a); dbg_wr_data = d;
    @(negedge clk);
    dbg_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [63:0] d;
    int depth [3] = '{32, 256, 256};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rsp_valid low after reset", 64'(rsp_valid), 64'd0);
    bus_rd(4'd0, d);
    check("R1 cursor zero after reset", d, 64'd0);

    // R10: fill all memories through the debug-write port
    for (int m = 0; m < 3; m++)
      for (int a = 0; a < depth[m]; a++) dbg_wr(m, a, pat(m, a));

    // R11 R4 R10: ordered dump of every memory, plus wrap to entry 0
    for (int m = 0; m < 3; m++) begin
      set_cursor(0, 1);
      for (int a = 0; a <= depth[m]; a++) begin
        bus_rd(4'(1 + m), d);
        check("R11 sequential dump", d, pat(m, a % depth[m]));
      end
    end

    // R2 R5: readback after dump of memory 2 -> index 257, stride 1
    bus_rd(4'd0, d);
    check("R2 R5 cursor readback", d, 64'h0000_0000_0001_0101);
    bus_rd(4'd0, d);
    check("R6 cursor read does not advance", d, 64'h0000_0000_0001_0101);

    // R2: reserved upper bits written as ones read as zero
    bus_wr(4'd0, 64'hFFFF_FFFF_0002_0005);
    bus_rd(4'd0, d);
    check("R2 upper bits zero", d, 64'h0000_0000_0002_0005);

    // R7: index above depth of 32-entry memory
    set_cursor(33, 0);
    bus_rd(4'd1, d);
    check("R7 index wraps modulo depth", d, pat(0, 1));
    // R8: stride zero rereads
    bus_rd(4'd1, d);
    check("R8 stride zero same entry", d, pat(0, 1));

    // R5: stride 3 across the end of memory 1
    set_cursor(250, 3);
    for (int k = 0; k < 4; k++) begin
      bus_rd(4'd2, d);
      check("R5 stride 3 wrap", d, pat(1, (250 + 3 * k) % 256));
    end

    // R5: stride -1 walking downward from entry 2 of memory 2
    set_cursor(2, 16'hFFFF);
    for (int k = 0; k < 4; k++) begin
      bus_rd(4'd3, d);
      check("R5 stride minus one", d, pat(2, (2 - k + 256) % 256));
    end

    // R5: 16-bit index overflow
    set_cursor(16'hFFFE, 3);
    bus_rd(4'd2, d);
    check("R5 read at 0xFFFE", d, pat(1, 254));
    bus_rd(4'd2, d);
    check("R5 read after 16-bit wrap", d, pat(1, 1));
    bus_rd(4'd0, d);
    check("R5 index wrapped modulo 2^16", d, 64'h0000_0000_0003_0004);

    // R6: unmapped reads return zero and leave the cursor alone
    for (int a = 4; a < 16; a++) begin
      bus_rd(4'(a), d);
      check("R6 unmapped read zero", d, 64'd0);
    end
    bus_rd(4'd0, d);
    check("R6 cursor unchanged by unmapped reads", d, 64'h0000_0000_0003_0004);

    // R9: bus write to a memory address is ignored
    set_cursor(7, 1);
    bus_wr(4'd2, 64'hDEAD_BEEF_DEAD_BEEF);
    bus_rd(4'd0, d);
    check("R9 cursor unchanged by memory write", d, 64'h0000_0000_0001_0007);
    bus_rd(4'd2, d);
    check("R9 memory contents unchanged", d, pat(1, 7));

    // R10: debug overwrite of one entry
    dbg_wr(0, 5, 64'h0123_4567_89AB_CDEF);
    set_cursor(5, 0);
    bus_rd(4'd1, d);
    check("R10 debug overwrite visible", d, 64'h0123_4567_89AB_CDEF);

    // R1: reset again clears the cursor
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 rsp_valid low after second reset", 64'(rsp_valid), 64'd0);
    bus_rd(4'd0, d);
    check("R1 cursor cleared by reset", d, 64'd0);

    done = 1;
    finish_run();
  end
endmodule